// File: doc/BRIEF.md
# Configurable Command/Address Registered Buffer

This block registers the command and address lines of a memory module on the rising clock edge and drives them back out. It runs in one of two shapes, picked at runtime by two static configuration inputs. In the wide shape every one of 25 data inputs drives one registered output. In the paired shape only the low 14 inputs take part, and each registered bit drives two outputs: a primary copy and a duplicate copy. A variant input then picks which of those 14 inputs are live. Inputs outside the live set produce zero.

Three control-path bits also have registered outputs: a chip select, a termination enable and a clock enable. In the paired shape each of them has a duplicate copy as well. When both active-low select inputs are high at a clock edge, the data outputs keep their values. The control-path outputs keep updating on every edge. An active-low reset clears every register at once, whatever the clock is doing. Its release passes through a synchronizer, so the outputs stay zero until the synchronizer has cleared. The configuration inputs may change only while reset is held low.

Top module: `cmdaddr_regbuf`

## Requirements
- R1: With `cfg_pair` low (wide shape), each bit `d_in[i]` for i = 0..24 appears on `q_a[i]` after the next rising edge.
- R2: With `cfg_pair` high (paired shape), `q_b[i]` equals `q_a[i]` for i = 0..13, and `q_a[24:14]` is zero.
- R3: In the paired shape with `cfg_variant` low, only inputs 1, 2, 4, 5 and 7 through 13 are captured. Bits 0, 3 and 6 of `q_a` and `q_b` read zero.
- R4: In the paired shape with `cfg_variant` high, only inputs 0 through 5, 7, 8, 9, 11 and 12 are captured. Bits 6, 10 and 13 of `q_a` and `q_b` read zero.
- R5: When `cs_n` and `cs_gate_n` are both high at a rising edge, `q_a` and `q_b` keep their previous values, whatever `d_in` is.
- R6: When either `cs_n` or `cs_gate_n` is low at a rising edge, `q_a` and `q_b` load the new masked input.
- R7: `cs_a_q`, `odt_a_q` and `cke_a_q` take the values of `cs_n`, `odt_in` and `cke_in` at every rising edge, including edges where the data outputs hold.
- R8: In the wide shape, `q_b`, `cs_b_q`, `odt_b_q` and `cke_b_q` are zero.
- R9: While `rst_n` is low, every output is zero at once, without waiting for a clock edge, even when both selects are high.
- R10: After `rst_n` rises, the first two rising edges leave every output at zero. The third rising edge is the first capture.
- R11: In the paired shape, `cs_b_q`, `odt_b_q` and `cke_b_q` equal `cs_a_q`, `odt_a_q` and `cke_a_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset with synchronized release |
| cfg_pair | input | 1 | 0: wide 25-bit shape, 1: paired 14-bit shape |
| cfg_variant | input | 1 | Live-bit variant for the paired shape |
| d_in | input | 25 | Command/address data inputs |
| cs_n | input | 1 | Active-low chip select; also drives the registered select outputs |
| cs_gate_n | input | 1 | Second active-low select; together with `cs_n` it gates the data capture |
| odt_in | input | 1 | Termination enable input |
| cke_in | input | 1 | Clock enable input |
| q_a | output | 25 | Primary registered data outputs |
| q_b | output | 14 | Duplicate registered data outputs (paired shape only) |
| cs_a_q | output | 1 | Registered chip select, primary |
| cs_b_q | output | 1 | Registered chip select, duplicate |
| odt_a_q | output | 1 | Registered termination enable, primary |
| odt_b_q | output | 1 | Registered termination enable, duplicate |
| cke_a_q | output | 1 | Registered clock enable, primary |
| cke_b_q | output | 1 | Registered clock enable, duplicate |

## Verification
Every data and control result is due one rising edge after its inputs are presented. The only exceptions are reset entry, which clears the outputs at once, and reset release, where the first capture comes on the third edge. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so each read sits half a period after the edge that produced it. Reset entry is read one nanosecond after `rst_n` falls, with no edge in between. After a release, the outputs are read after each of the first three edges, so the two zero cycles and the first capture are each seen on their own edge.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    typedef enum logic [1:0] {
        SHAPE_WIDE   = 2'd0,
        SHAPE_PAIR_A = 2'd1,
        SHAPE_PAIR_B = 2'd2
    } shape_e;

    // Decode the two static configuration pins into a shape.
    function automatic shape_e decode_shape(input logic pair, input logic variant);
        if (!pair)
            return SHAPE_WIDE;
        else if (!variant)
            return SHAPE_PAIR_A;
        else
            return SHAPE_PAIR_B;
    endfunction

    // Whether lane idx is live in the given shape.
    function automatic logic lane_live(input shape_e shp, input int idx, input int narrow_w);
        logic live;
        case (shp)
            SHAPE_WIDE:   live = 1'b1;
            SHAPE_PAIR_A: live = (idx < narrow_w) && (idx != 0) && (idx != 3) && (idx != 6);
            SHAPE_PAIR_B: live = (idx < narrow_w) && (idx != 6) && (idx != 10) && (idx != 13);
            default:      live = 1'b0;
        endcase
        return live;
    endfunction

endpackage

// File: rtl/regbuf_rst_sync.sv
module regbuf_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic run_q
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= chain_d;
    end

    assign run_q = chain_q[STAGES-1];
endmodule

// File: rtl/regbuf_lane_mask.sv
module regbuf_lane_mask
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  logic              cfg_pair,
    input  logic              cfg_variant,
    output logic [WIDE_W-1:0] live_mask
);
    shape_e shape;

    always_comb begin
        shape = decode_shape(cfg_pair, cfg_variant);
    end

    for (genvar i = 0; i < WIDE_W; i++) begin : g_lane
        always_comb begin
            live_mask[i] = lane_live(shape, i, NARROW_W);
        end
    end
endmodule

// File: rtl/cmdaddr_regbuf.sv
module cmdaddr_regbuf #(
    parameter int WIDE_W      = 25,
    parameter int NARROW_W    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_pair,
    input  logic                cfg_variant,
    input  logic [WIDE_W-1:0]   d_in,
    input  logic                cs_n,
    input  logic                cs_gate_n,
    input  logic                odt_in,
    input  logic                cke_in,
    output logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b,
    output logic                cs_a_q,
    output logic                cs_b_q,
    output logic                odt_a_q,
    output logic                odt_b_q,
    output logic                cke_a_q,
    output logic                cke_b_q
);
    typedef struct packed {
        logic [WIDE_W-1:0]   dat_a;
        logic [NARROW_W-1:0] dat_b;
        logic                cs_a;
        logic                cs_b;
        logic                odt_a;
        logic                odt_b;
        logic                cke_a;
        logic                cke_b;
    } bank_t;

    bank_t             bank_d;
    bank_t             bank_q;
    logic              run_q;
    logic [WIDE_W-1:0] live_mask;
    logic [WIDE_W-1:0] masked_d;
    logic              hold;

    regbuf_rst_sync #(
        .STAGES (SYNC_STAGES)
    ) u_rst_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .run_q (run_q)
    );

    regbuf_lane_mask #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_lane_mask (
        .cfg_pair    (cfg_pair),
        .cfg_variant (cfg_variant),
        .live_mask   (live_mask)
    );

    always_comb begin
        masked_d = d_in & live_mask;
        hold     = cs_n & cs_gate_n;
        bank_d   = bank_q;
        if (!run_q) begin
            bank_d = '0;
        end else begin
            if (!hold) begin
                bank_d.dat_a = masked_d;
                bank_d.dat_b = cfg_pair ? masked_d[NARROW_W-1:0] : '0;
            end
            bank_d.cs_a  = cs_n;
            bank_d.odt_a = odt_in;
            bank_d.cke_a = cke_in;
            bank_d.cs_b  = cfg_pair & cs_n;
            bank_d.odt_b = cfg_pair & odt_in;
            bank_d.cke_b = cfg_pair & cke_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    assign q_a     = bank_q.dat_a;
    assign q_b     = bank_q.dat_b;
    assign cs_a_q  = bank_q.cs_a;
    assign cs_b_q  = bank_q.cs_b;
    assign odt_a_q = bank_q.odt_a;
    assign odt_b_q = bank_q.odt_b;
    assign cke_a_q = bank_q.cke_a;
    assign cke_b_q = bank_q.cke_b;
endmodule

// File: rtl/cmdaddr_regbuf_chk.sv
module cmdaddr_regbuf_chk #(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_q,
    input logic                cfg_pair,
    input logic                cs_n,
    input logic                cs_gate_n,
    input logic                odt_in,
    input logic                cke_in,
    input logic [WIDE_W-1:0]   q_a,
    input logic [NARROW_W-1:0] q_b,
    input logic                cs_a_q,
    input logic                cs_b_q,
    input logic                odt_a_q,
    input logic                odt_b_q,
    input logic                cke_a_q,
    input logic                cke_b_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !cs_a_q && !odt_a_q && !cke_a_q)); // R9

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cs_n && cs_gate_n) |=> ($stable(q_a) && $stable(q_b))); // R5

    AST_CTL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (cs_a_q == $past(cs_n) && odt_a_q == $past(odt_in) && cke_a_q == $past(cke_in))); // R7

    AST_DUP_OFF_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pair |-> (q_b == '0 && !cs_b_q && !odt_b_q && !cke_b_q)); // R8

    AST_PAIR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pair |-> (q_b == q_a[NARROW_W-1:0] && q_a[WIDE_W-1:NARROW_W] == '0)); // R2

    AST_PAIR_CTL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pair |-> (cs_b_q == cs_a_q && odt_b_q == odt_a_q && cke_b_q == cke_a_q)); // R11

    AST_IDLE_UNTIL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (q_a == '0 && !cs_a_q)); // R10
endmodule

bind cmdaddr_regbuf cmdaddr_regbuf_chk #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (run_q),
    .cfg_pair  (cfg_pair),
    .cs_n      (cs_n),
    .cs_gate_n (cs_gate_n),
    .odt_in    (odt_in),
    .cke_in    (cke_in),
    .q_a       (q_a),
    .q_b       (q_b),
    .cs_a_q    (cs_a_q),
    .cs_b_q    (cs_b_q),
    .odt_a_q   (odt_a_q),
    .odt_b_q   (odt_b_q),
    .cke_a_q   (cke_a_q),
    .cke_b_q   (cke_b_q)
);

// File: tb/cmdaddr_regbuf_tb_top.sv
module cmdaddr_regbuf_tb_top;
    localparam int WW = 25;
    localparam int NW = 14;
    localparam logic [WW-1:0] MASK_PA = 25'h0003FB6;
    localparam logic [WW-1:0] MASK_PB = 25'h0001BBF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          cfg_pair = 1'b0;
    logic          cfg_variant = 1'b0;
    logic [WW-1:0] d_in = '0;
    logic          cs_n = 1'b0;
    logic          cs_gate_n = 1'b0;
    logic          odt_in = 1'b0;
    logic          cke_in = 1'b0;
    logic [WW-1:0] q_a;
    logic [NW-1:0] q_b;
    logic          cs_a_q, cs_b_q, odt_a_q, odt_b_q, cke_a_q, cke_b_q;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cmdaddr_regbuf dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_pair (cfg_pair), .cfg_variant (cfg_variant),
        .d_in (d_in), .cs_n (cs_n), .cs_gate_n (cs_gate_n), .odt_in (odt_in), .cke_in (cke_in),
        .q_a (q_a), .q_b (q_b), .cs_a_q (cs_a_q), .cs_b_q (cs_b_q),
        .odt_a_q (odt_a_q), .odt_b_q (odt_b_q), .cke_a_q (cke_a_q), .cke_b_q (cke_b_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [5:0] ctl_bits();
        return {cs_a_q, cs_b_q, odt_a_q, odt_b_q, cke_a_q, cke_b_q};
    endfunction

    // Enter reset, change shape, release and wait for the first capture edge.
    task automatic set_shape(input logic pair, input logic variant);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        cfg_pair = pair;
        cfg_variant = variant;
        d_in = '0;
        cs_n = 1'b0;
        cs_gate_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) cycle();
    endtask

    task automatic t_reset_entry();
        d_in = '1; cs_n = 1'b1; cs_gate_n = 1'b0; odt_in = 1'b1; cke_in = 1'b1;
        cycle();
        check("R1 preload", q_a, 32'h1FFFFFF);
        cs_gate_n = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R9 data cleared", q_a, 32'h0);
        check("R9 ctl cleared", ctl_bits(), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cs_gate_n = 1'b0;
    endtask

    task automatic t_release();
        rst_n = 1'b0;
        #1;
        d_in = '1; cs_n = 1'b0; cs_gate_n = 1'b0; cke_in = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        cycle();
        check("R10 edge1 zero", {q_a, cke_a_q}, 32'h0);
        cycle();
        check("R10 edge2 zero", {q_a, cke_a_q}, 32'h0);
        cycle();
        check("R10 edge3 capture", {q_a, cke_a_q}, 32'h3FFFFFF);
    endtask

    task automatic t_wide();
        logic [WW-1:0] pats [3] = '{25'h1555555, 25'h0AAAAAA, 25'h1234567};
        set_shape(1'b0, 1'b0);
        cs_n = 1'b0; cs_gate_n = 1'b1; odt_in = 1'b1; cke_in = 1'b0;
        foreach (pats[k]) begin
            d_in = pats[k];
            cycle();
            check("R1 wide data", q_a, 32'(pats[k]));
            check("R8 dup off", {18'h0, q_b}, 32'h0);
            check("R8 dup ctl off", {cs_b_q, odt_b_q, cke_b_q}, 32'h0);
        end
    endtask

    task automatic t_pair(input logic variant, input logic [WW-1:0] mask, input string req);
        logic [WW-1:0] pats [2] = '{25'h1FFFFFF, 25'h1F0F3C5};
        set_shape(1'b1, variant);
        cs_n = 1'b1; cs_gate_n = 1'b0; odt_in = 1'b0; cke_in = 1'b1;
        foreach (pats[k]) begin
            d_in = pats[k];
            cycle();
            check({req, " primary"}, q_a, 32'(pats[k] & mask));
            check({req, " R2 duplicate"}, {18'h0, q_b}, 32'(pats[k] & mask));
            check("R11 ctl dup", {cs_b_q, odt_b_q, cke_b_q}, {29'h0, cs_a_q, odt_a_q, cke_a_q});
        end
        check("R11 ctl values", {cs_b_q, odt_b_q, cke_b_q}, 32'h5);
    endtask

    task automatic t_gate();
        set_shape(1'b0, 1'b0);
        d_in = 25'h0F0F0F0; cs_n = 1'b0; cs_gate_n = 1'b0; odt_in = 1'b0; cke_in = 1'b0;
        cycle();
        check("R6 both low load", q_a, 32'h0F0F0F0);
        d_in = 25'h1111111; cs_n = 1'b1; cs_gate_n = 1'b1; odt_in = 1'b1; cke_in = 1'b1;
        cycle();
        check("R5 hold", q_a, 32'h0F0F0F0);
        check("R7 ctl during hold", {cs_a_q, odt_a_q, cke_a_q}, 32'h7);
        d_in = 25'h1222222; odt_in = 1'b0;
        cycle();
        check("R5 hold second edge", q_a, 32'h0F0F0F0);
        check("R7 odt follows", odt_a_q, 32'h0);
        cs_gate_n = 1'b0;
        cycle();
        check("R6 gate low load", q_a, 32'h1222222);
        d_in = 25'h0333333; cs_n = 1'b0; cs_gate_n = 1'b1;
        cycle();
        check("R6 cs low load", q_a, 32'h0333333);
        check("R7 cs follows", cs_a_q, 32'h0);
    endtask

    task automatic t_pair_hold();
        set_shape(1'b1, 1'b1);
        d_in = 25'h0003FFF; cs_n = 1'b0; cs_gate_n = 1'b1;
        cycle();
        d_in = 25'h0000000; cs_n = 1'b1;
        cycle();
        check("R5 pair hold primary", q_a, 32'(25'h0003FFF & MASK_PB));
        check("R5 pair hold duplicate", {18'h0, q_b}, 32'(25'h0003FFF & MASK_PB));
    endtask

    initial begin
        #1 rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 reset state", {q_a, ctl_bits()}, 32'h0);
        rst_n = 1'b1;
        repeat (3) cycle();
        t_reset_entry();
        t_release();
        t_wide();
        t_pair(1'b0, MASK_PA, "R3");
        t_pair(1'b1, MASK_PB, "R4");
        t_gate();
        t_pair_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule